// File: doc/BRIEF.md
# Matrix-Vector Affine Compute Engine

This block computes the affine product y = 2·A·x + b. A is a 16×16 matrix and x, b and y are 16-element vectors. Every element is an 8-bit unsigned value, and each result is kept modulo 256. The vectors x and b come in on flat 128-bit buses that do not change during a computation. The matrix sits in an external synchronous read-only memory that holds one matrix row per word. The engine drives a row address and gets that row back one clock later on a 128-bit data input. It forms the row's dot product with x in a single cycle, doubles it, adds the matching element of b, and writes the result into a result register selected by the row number.

A small state machine sets the order of work. Its states are:
- `ST_PRIME`: one cycle. Address 0 is presented, the memory latency is absorbed and the stale data word is ignored.
- `ST_FETCH`: sixteen cycles. Each cycle writes one result row while the address runs one row ahead.
- `ST_DONE`: terminal. The done flag is raised, and the results and the address stay frozen until the next reset.

Its transitions are:
- *prime_to_fetch*: taken on the first clock after reset.
- *fetch_next*: taken while the row counter is below 15.
- *fetch_to_done*: taken as row 15 is written.
- *done_hold*: a self-loop.

The reset is asynchronous and active high. It returns the engine to `ST_PRIME` from any state.

Top module: `mva_engine`

## Requirements
- R1: While reset is high, and after it is released but before the first rising edge, `done` is 0, `row_addr` is 0 and `res_y` is all zeros.
- R2: Element k of every 128-bit bus sits in bits [8k+7:8k]. Matrix element (i,j) sits in bits [8j+7:8j] of memory word i. When `done` is 1, element i of `res_y` equals 2·Σ_j A(i,j)·x(j) + b(i), taken modulo 256.
- R3: Overflow wraps silently. With every element of A, x and b at 255, every result element is 31.
- R4: After the k-th rising edge following reset release, `row_addr` equals k for k from 1 to 15. It then stays at 15.
- R5: `done` is 0 after each of the first 16 rising edges following reset release. It is 1 after the 17th.
- R6: Once `done` is 1, it stays 1 and `res_y` does not change until reset, whatever values appear on `row_word`.
- R7: Asserting reset in the middle of a computation clears `done`, `row_addr` and `res_y` at once, without a clock edge. A computation started after that reset produces correct results for the new data.
- R8: The memory returns the word one clock after its address. The data word present during the first cycle after reset is never used as a matrix row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| vec_x | input | 128 | Multiplicand vector x, element k at [8k+7:8k] |
| vec_b | input | 128 | Offset vector b, element k at [8k+7:8k] |
| row_word | input | 128 | Memory data: the matrix row addressed one cycle earlier |
| row_addr | output | 4 | Memory row address |
| res_y | output | 128 | Result vector y, element k at [8k+7:8k] |
| done | output | 1 | High once all 16 result elements are valid |

## Verification
If the row counter and the address drift apart, data is credited to the wrong row. This appears as shifted or duplicated results in `res_y` when `done` rises, 17 cycles after reset. If the stale word is not discarded, as R8 requires, row 0 takes the value of the word on the bus at reset. A state register that leaves `ST_DONE`, or a write enable that stays active, shows within one cycle: `done` drops, or `res_y` changes after garbage is driven on `row_word`. An address sequence or done flag that is off by one shows at the exact edge where the bench expects the step.

// File: rtl/mva_pkg.sv
package mva_pkg;
    localparam int ELEMS  = 16;
    localparam int EW     = 8;
    localparam int IDX_W  = $clog2(ELEMS);
    localparam int BUS_W  = ELEMS * EW;
    localparam int PROD_W = 2 * EW;
    localparam int ACC_W  = PROD_W + IDX_W + 1;

    typedef enum logic [1:0] {
        ST_PRIME,
        ST_FETCH,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/mva_row_seq.sv
module mva_row_seq
    import mva_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] row_addr,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ELEMS - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] row_q, row_d;
    logic [IDX_W-1:0] addr_q, addr_d;

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_PRIME;
            row_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            addr_q  <= addr_d;
        end
    end

    // Next state and counters
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        addr_d  = addr_q;
        unique case (state_q)
            ST_PRIME: begin
                state_d = ST_FETCH;
                addr_d  = addr_q + IDX_W'(1);
            end
            ST_FETCH: begin
                if (row_q == LAST) begin
                    state_d = ST_DONE;
                end else begin
                    row_d = row_q + IDX_W'(1);
                end
                if (addr_q != LAST) begin
                    addr_d = addr_q + IDX_W'(1);
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: state_d = ST_PRIME;
        endcase
    end

    // Outputs
    always_comb begin
        row_addr = addr_q;
        wr_idx   = row_q;
        wr_en    = (state_q == ST_FETCH);
        done     = (state_q == ST_DONE);
    end

    // R4: address steps by one per cycle until it reaches the last row
    a_r4_addr_advance: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_DONE && addr_q != LAST) |=> addr_q == $past(addr_q) + IDX_W'(1));

    // R5: done rises only after the last row was written
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(row_q) == LAST && $past(wr_en)));

    // R6: done is sticky
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R8: no write in the priming cycle
    a_r8_no_prime_write: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRIME) |-> !wr_en);
endmodule

// File: rtl/mva_row_dot.sv
module mva_row_dot
    import mva_pkg::*;
(
    input  logic [BUS_W-1:0] row_word,
    input  logic [BUS_W-1:0] vec_x,
    input  logic [BUS_W-1:0] vec_b,
    input  logic [IDX_W-1:0] idx,
    output logic [EW-1:0]    val
);
    logic [PROD_W-1:0] prod [ELEMS];
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  dbl;
    logic [EW-1:0]     b_sel;

    for (genvar j = 0; j < ELEMS; j++) begin : g_mul
        assign prod[j] = row_word[j*EW +: EW] * vec_x[j*EW +: EW];
    end

    always_comb begin
        acc = '0;
        for (int j = 0; j < ELEMS; j++) begin
            acc = acc + ACC_W'(prod[j]);
        end
        dbl   = acc << 1;
        b_sel = vec_b[idx*EW +: EW];
        val   = dbl[EW-1:0] + b_sel;
    end
endmodule

// File: rtl/mva_result_bank.sv
module mva_result_bank
    import mva_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [EW-1:0]    wr_val,
    output logic [BUS_W-1:0] y_flat
);
    for (genvar k = 0; k < ELEMS; k++) begin : g_slot
        logic [EW-1:0] slot_q;
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                slot_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(k)) begin
                slot_q <= wr_val;
            end
        end
        assign y_flat[k*EW +: EW] = slot_q;
    end

    // R6: without a write the result vector holds
    a_r6_y_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(y_flat));
endmodule

// File: rtl/mva_engine.sv
module mva_engine
    import mva_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] vec_x,
    input  logic [BUS_W-1:0] vec_b,
    input  logic [BUS_W-1:0] row_word,
    output logic [IDX_W-1:0] row_addr,
    output logic [BUS_W-1:0] res_y,
    output logic             done
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [EW-1:0]    wr_val;

    mva_row_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .row_addr (row_addr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .done     (done)
    );

    mva_row_dot u_dot (
        .row_word (row_word),
        .vec_x    (vec_x),
        .vec_b    (vec_b),
        .idx      (wr_idx),
        .val      (wr_val)
    );

    mva_result_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_val (wr_val),
        .y_flat (res_y)
    );

    // R1: reset state seen at the ports
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |-> (!done && row_addr == '0 && res_y == '0));
endmodule

// File: tb/mva_engine_test.sv
`timescale 1ns/1ps
module mva_engine_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] vec_x = '0;
    logic [127:0] vec_b = '0;
    logic [127:0] q_word = '0;
    logic [3:0]   row_addr;
    logic [127:0] res_y;
    logic         done;

    logic [127:0] mem [16];
    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    // Behavioural synchronous read memory, one cycle latency
    always @(posedge clk) q_word <= mem[row_addr];

    mva_engine uut (
        .clk(clk), .rst(rst), .vec_x(vec_x), .vec_b(vec_b),
        .row_word(q_word), .row_addr(row_addr), .res_y(res_y), .done(done)
    );

    function automatic logic [7:0] ref_elem(input int i);
        logic [31:0] s;
        s = 0;
        for (int j = 0; j < 16; j++) s += mem[i][j*8 +: 8] * vec_x[j*8 +: 8];
        return 8'((s << 1) + vec_b[i*8 +: 8]);
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Release reset, walk 17 edges checking address (R4) and done (R5), then results
    task automatic run_and_check(input string tag);
        logic [127:0] exp;
        @(negedge clk);
        rst = 1'b0;
        check({"R1 ", tag}, {res_y[126:0], done}, '0);
        check({"R1 addr ", tag}, 128'(row_addr), '0);
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            check({"R4 ", tag}, 128'(row_addr), 128'((k > 15) ? 15 : k));
            check({"R5 ", tag}, 128'(done), 128'(k == 17));
        end
        for (int i = 0; i < 16; i++) exp[i*8 +: 8] = ref_elem(i);
        check({"R2 ", tag}, res_y, exp);
    endtask

    task automatic fill_zero();
        for (int i = 0; i < 16; i++) mem[i] = '0;
        vec_x = '0;
        vec_b = '0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        fill_zero();
        @(negedge clk);
        check("R1 reset y", res_y, '0);
        check("R1 reset addr/done", {123'd0, row_addr, done}, '0);
    endtask

    task automatic t_worked_example();
        rst = 1'b1;
        fill_zero();
        mem[0][7:0] = 8'd1; mem[0][15:8] = 8'd2;
        mem[1][7:0] = 8'd3; mem[1][15:8] = 8'd4;
        vec_x[7:0] = 8'd3; vec_x[15:8] = 8'd2;
        vec_b[7:0] = 8'd2; vec_b[15:8] = 8'd6;
        run_and_check("worked");
        check("R2 worked y0", 128'(res_y[7:0]), 128'd16);
        check("R2 worked y1", 128'(res_y[15:8]), 128'd40);
    endtask

    task automatic t_overflow();
        rst = 1'b1;
        for (int i = 0; i < 16; i++) mem[i] = '1;
        vec_x = '1;
        vec_b = '1;
        run_and_check("wrap");
        check("R3 all-ones result", res_y, {16{8'd31}});
    endtask

    task automatic t_random(input int seed);
        int s;
        rst = 1'b1;
        s = $urandom(seed);
        for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom, $urandom, $urandom};
        vec_x = {$urandom, $urandom, $urandom, $urandom};
        vec_b = {$urandom, $urandom, $urandom, $urandom};
        run_and_check("random");
    endtask

    // Distinct diagonal rows with a stale word at reset: exposes R8 and row indexing
    task automatic t_row_order();
        rst = 1'b1;
        fill_zero();
        for (int i = 0; i < 16; i++) begin
            mem[i][i*8 +: 8] = 8'(i + 1);
            vec_x[i*8 +: 8] = 8'd1;
            vec_b[i*8 +: 8] = 8'(i);
        end
        @(negedge clk);
        q_word = '1;
        run_and_check("order");
        check("R8 row0 not stale", 128'(res_y[7:0]), 128'd2);
    endtask

    // After done, scramble memory and check freeze
    task automatic t_hold();
        logic [127:0] snap;
        snap = res_y;
        for (int i = 0; i < 16; i++) mem[i] = {4{$urandom}};
        repeat (6) @(negedge clk);
        check("R6 done stays", 128'(done), 128'd1);
        check("R6 y stable", res_y, snap);
        check("R6 addr holds", 128'(row_addr), 128'd15);
    endtask

    task automatic t_async_reset();
        rst = 1'b1;
        fill_zero();
        for (int i = 0; i < 16; i++) mem[i] = {16{8'(i + 3)}};
        vec_x = {16{8'd5}};
        vec_b = {16{8'd9}};
        @(negedge clk);
        rst = 1'b0;
        repeat (9) @(negedge clk);
        #1 rst = 1'b1;
        #1;
        check("R7 async clear y", res_y, '0);
        check("R7 async clear addr/done", {123'd0, row_addr, done}, '0);
        for (int i = 0; i < 16; i++) mem[i] = {16{8'(2 * i + 1)}};
        vec_x = {16{8'd7}};
        run_and_check("R7 restart");
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_worked_example();
        t_hold();
        t_overflow();
        t_row_order();
        t_random(11);
        t_hold();
        t_random(47);
        t_async_reset();
        t_hold();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule